// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches every line of a GPIO bank (32 lines by default) for a selectable input event and gathers the results into one interrupt request. Each line receives a 3-bit event select that picks a falling edge, a rising edge, any edge, a low level or a high level. A detected event latches a pending bit for that line. Software sets or clears the per-line enable mask through two write-one registers and collects pending events by reading a status register, which empties itself on the read.

The line inputs are expected to be already synchronized to the block clock; glitch filtering and the storage of the per-line event selects live outside. The single interrupt output stays high while any pending line is also enabled, so one request covers the whole bank.

Top module: `gpio_evt_irq`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears the enable mask and the pending register and loads the previous-sample register with the current inputs, so an input already high at reset release gives no edge event.
- R2: Event select codes (line i uses `evt_sel[3*i+2:3*i]`): 0 flags a 1-to-0 change, 1 flags a 0-to-1 change, 2 flags either change, where a change is the current input against its value one cycle earlier; the opposite change of an edge-only mode flags nothing.
- R3: Code 3 flags every cycle the input is 0 and code 4 flags every cycle it is 1, so a persisting level makes the pending bit come back right after it is read.
- R4: Codes 5, 6 and 7 never set a pending bit, whatever the input does.
- R5: A write to offset 0x20 sets the mask bits where the write data is 1, a write to 0x24 clears them; zero data bits leave the mask unchanged. Reading offset 0x28 returns the mask.
- R6: Reading offset 0x2C returns the pending bits and clears them at the clock edge that ends the read; without such a read a pending bit never clears.
- R7: An event detected at the same edge as a pending-register read stays pending after that read.
- R8: Pending bits are set whether or not the line is enabled; `irq` is high exactly while some line is both pending and enabled.
- R9: Writes to offsets 0x28 and 0x2C change nothing, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | NLINES | Synchronized line levels |
| evt_sel | input | 3*NLINES | Per-line event select, line i at bits 3*i+2..3*i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, valid in the cycle `reg_rd` is high |
| irq | output | 1 | Combined bank interrupt |

## Verification
The assertions take for granted that `line_in` and `evt_sel` are settled before each rising edge, that at most one write and one read address are presented per cycle, and that the event selects are held while a line is being judged by the reserved-code property. The stimulus changes every input only at the falling clock edge, performs one register access per cycle, and moves line levels one step at a time so that each edge and level case is separated from its neighbours.

// File: rtl/gei_pkg.sv
package gei_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        EV_FALL = 3'd0,
        EV_RISE = 3'd1,
        EV_ANY  = 3'd2,
        EV_LOW  = 3'd3,
        EV_HIGH = 3'd4
    } ev_mode_e;

    localparam int OFS_ENA  = 'h20;
    localparam int OFS_DIS  = 'h24;
    localparam int OFS_MASK = 'h28;
    localparam int OFS_STAT = 'h2C;
endpackage

// File: rtl/gei_line_detect.sv
module gei_line_detect
    import gei_pkg::*;
(
    input  logic [SEL_W-1:0] mode,
    input  logic             prev,
    input  logic             cur,
    output logic             hit
);
    always_comb begin
        case (mode)
            EV_FALL: hit = prev & ~cur;
            EV_RISE: hit = ~prev & cur;
            EV_ANY:  hit = prev ^ cur;
            EV_LOW:  hit = ~cur;
            EV_HIGH: hit = cur;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gei_event_array.sv
module gei_event_array
    import gei_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0]       line_cur,
    input  logic [NLINES-1:0]       line_prev,
    input  logic [NLINES*SEL_W-1:0] evt_sel,
    output logic [NLINES-1:0]       events
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        gei_line_detect u_det (
            .mode (evt_sel[i*SEL_W +: SEL_W]),
            .prev (line_prev[i]),
            .cur  (line_cur[i]),
            .hit  (events[i])
        );
    end
endmodule

// File: rtl/gei_reg_core.sv
module gei_reg_core
    import gei_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] events,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] status_q
);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    typedef struct packed {
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] status;
    } core_t;

    core_t cs_q, cs_d;
    logic  rd_stat;

    always_comb begin
        cs_d      = cs_q;
        reg_rdata = '0;
        rd_stat   = reg_rd && (reg_addr == A_STAT);

        if (reg_rd) begin
            if (reg_addr == A_MASK)
                reg_rdata = cs_q.mask;
            else if (reg_addr == A_STAT)
                reg_rdata = cs_q.status;
        end

        if (reg_wr) begin
            if (reg_addr == A_ENA)
                cs_d.mask = cs_q.mask | reg_wdata;
            else if (reg_addr == A_DIS)
                cs_d.mask = cs_q.mask & ~reg_wdata;
        end

        // clear-on-read first, then new events, so a coincident event survives
        cs_d.status = (rd_stat ? '0 : cs_q.status) | events;

        if (!rst_n)
            cs_d = '0;
    end

    always_ff @(posedge clk) begin
        cs_q <= cs_d;
    end

    assign mask_q   = cs_q.mask;
    assign status_q = cs_q.status;
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
    import gei_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLINES-1:0]       line_in,
    input  logic [NLINES*SEL_W-1:0] evt_sel,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [NLINES-1:0]       reg_wdata,
    output logic [NLINES-1:0]       reg_rdata,
    output logic                    irq
);
    logic [NLINES-1:0] prev_q, prev_d;
    logic [NLINES-1:0] events;
    logic [NLINES-1:0] mask_q;
    logic [NLINES-1:0] status_q;

    // in reset and in operation alike the sample register follows the input,
    // so the first cycle after reset compares the input with itself
    always_comb begin
        prev_d = line_in;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    gei_event_array #(.NLINES(NLINES)) u_events (
        .line_cur  (line_in),
        .line_prev (prev_q),
        .evt_sel   (evt_sel),
        .events    (events)
    );

    gei_reg_core #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    (events),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask_q    (mask_q),
        .status_q  (status_q)
    );

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/gei_checker.sv
module gei_checker
    import gei_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic                    reg_rd,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [NLINES-1:0]       reg_wdata,
    input logic [NLINES*SEL_W-1:0] evt_sel,
    input logic [NLINES-1:0]       mask,
    input logic [NLINES-1:0]       status,
    input logic                    irq
);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(OFS_ENA);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask == '0 && status == '0));

    p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENA) |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));

    p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIS) |=> ((mask & $past(reg_wdata)) == '0));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_ENA || reg_addr == A_DIS)) |=> $stable(mask));

    p_sticky_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_STAT) |=> ((~status & $past(status)) == '0));

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0 || mask == '0) |-> !irq);

    for (genvar i = 0; i < NLINES; i++) begin : g_rsv
        p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_sel[i*SEL_W +: SEL_W] >= 3'd5 && !status[i]) |=> !status[i]);
    end
endmodule

bind gpio_evt_irq gei_checker #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .evt_sel   (evt_sel),
    .mask      (mask_q),
    .status    (status_q),
    .irq       (irq)
);

// File: tb/gpio_evt_irq_tb_top.sv
`timescale 1ns/100ps
module gpio_evt_irq_tb_top;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '0;
    logic [N*3-1:0] evt_sel = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [N-1:0]  reg_wdata = '0;
    logic [N-1:0]  reg_rdata;
    logic          irq;

    bit [N-1:0] m_mask, m_stat, m_prev;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] rv;

    always #2.5 clk = ~clk;

    gpio_evt_irq #(.NLINES(N), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .evt_sel(evt_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit ev_hit(input int code, input bit p, input bit c);
        case (code)
            0: return p && !c;
            1: return !p && c;
            2: return p != c;
            3: return !c;
            4: return c;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit [N-1:0] ev;
        if (!rst_n) begin
            m_mask = '0; m_stat = '0; m_prev = line_in;
            return;
        end
        ev = '0;
        for (int i = 0; i < N; i++)
            ev[i] = ev_hit(int'(evt_sel[i*3 +: 3]), m_prev[i], line_in[i]);
        if (reg_rd && reg_addr == 8'h2C) m_stat = '0;
        m_stat |= ev;
        if (reg_wr && reg_addr == 8'h20) m_mask |= reg_wdata;
        else if (reg_wr && reg_addr == 8'h24) m_mask &= ~reg_wdata;
        m_prev = line_in;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R8 irq vs model", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    endtask

    task automatic do_read(input logic [7:0] a, input string tag, output logic [N-1:0] v);
        logic [N-1:0] exp;
        reg_rd = 1'b1; reg_addr = a;
        #1;
        exp = (a == 8'h28) ? m_mask : (a == 8'h2C) ? m_stat : '0;
        v = reg_rdata;
        chk(tag, v, exp);
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [N-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic set_sel(input int ln, input logic [2:0] code);
        evt_sel[ln*3 +: 3] = code;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) set_sel(i, 3'd5);
        set_sel(0, 3'd1); set_sel(1, 3'd0); set_sel(2, 3'd2);
        set_sel(3, 3'd3); set_sel(4, 3'd4);
        set_sel(5, 3'd5); set_sel(6, 3'd6); set_sel(7, 3'd7);
        line_in = 32'hFFFF_000C;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: cleared registers, no false edge on line 2 (any-edge, high at reset)
        do_read(8'h28, "R1 mask after reset", rv);  chk("R1 mask zero", rv, '0);
        do_read(8'h2C, "R1 no false edge", rv);     chk("R1 status zero", rv, '0);

        // R5 mask set/clear, R9 writes to read-only offsets
        do_write(8'h20, 32'hF0);
        do_read(8'h28, "R5 enable", rv);   chk("R5 mask F0", rv, 32'hF0);
        do_write(8'h20, 32'h03);
        do_read(8'h28, "R5 enable zeros keep", rv); chk("R5 mask F3", rv, 32'hF3);
        do_write(8'h24, 32'h30);
        do_read(8'h28, "R5 disable", rv);  chk("R5 mask C3", rv, 32'hC3);
        do_write(8'h28, '1);
        do_read(8'h28, "R9 mask write ignored", rv); chk("R9 mask C3", rv, 32'hC3);
        do_write(8'h2C, '1);
        do_read(8'h2C, "R9 status write ignored", rv); chk("R9 status zero", rv, '0);
        do_read(8'h30, "R9 unmapped read", rv); chk("R9 unmapped zero", rv, '0);

        // R2 rising edge, R6 clear on read
        line_in[0] = 1'b1; tick();
        do_read(8'h2C, "R2 rise", rv);     chk("R2 rise bit0", rv, 32'h1);
        do_read(8'h2C, "R6 cleared", rv);  chk("R6 empty after read", rv, '0);

        // R2 opposite edges ignored
        line_in[0] = 1'b0; line_in[1] = 1'b1; tick();
        do_read(8'h2C, "R2 opposite edges", rv); chk("R2 no event", rv, '0);

        // R2 fall and any-edge
        line_in[1] = 1'b0; line_in[2] = 1'b0; tick();
        line_in[2] = 1'b1; tick();
        do_read(8'h2C, "R2 fall and any", rv); chk("R2 bits 1,2", rv, 32'h6);

        // R3 low level re-arms after read
        line_in[3] = 1'b0; tick(); tick();
        do_read(8'h2C, "R3 low", rv);          chk("R3 low bit3", rv, 32'h8);
        do_read(8'h2C, "R3 low re-arms", rv);  chk("R3 low again", rv, 32'h8);
        line_in[3] = 1'b1; tick();
        do_read(8'h2C, "R3 last low", rv);     chk("R3 last low bit3", rv, 32'h8);
        do_read(8'h2C, "R3 low gone", rv);     chk("R3 quiet", rv, '0);

        // R3 high level
        line_in[4] = 1'b1; tick();
        do_read(8'h2C, "R3 high", rv);         chk("R3 high bit4", rv, 32'h10);
        line_in[4] = 1'b0; tick();
        do_read(8'h2C, "R3 high drain", rv);
        do_read(8'h2C, "R3 high gone", rv);    chk("R3 high quiet", rv, '0);

        // R4 reserved codes
        line_in[7:5] = 3'b111; tick();
        line_in[7:5] = 3'b000; tick();
        line_in[7:5] = 3'b101; line_in[20] = 1'b0; tick();
        do_read(8'h2C, "R4 reserved", rv);     chk("R4 reserved quiet", rv, '0);

        // R7 event coincident with read
        line_in[0] = 1'b1;
        do_read(8'h2C, "R7 read with event", rv); chk("R7 old value", rv, '0);
        do_read(8'h2C, "R7 kept", rv);            chk("R7 event kept", rv, 32'h1);

        // R8 mask gates only irq
        line_in[1] = 1'b1; tick();
        line_in[1] = 1'b0; tick();
        chk("R8 enabled pending raises irq", {31'b0, irq}, 32'h1);
        do_write(8'h24, 32'h2);
        chk("R8 masked drops irq", {31'b0, irq}, 32'h0);
        do_read(8'h2C, "R8 status kept masked", rv); chk("R8 bit1 pending", rv, 32'h2);
        line_in[2] = 1'b0; tick();
        chk("R8 unenabled event no irq", {31'b0, irq}, 32'h0);
        do_write(8'h20, 32'h4);
        chk("R8 enable pending raises irq", {31'b0, irq}, 32'h1);
        do_read(8'h2C, "R8 read bit2", rv);    chk("R8 bit2", rv, 32'h4);
        chk("R8 irq drops after read", {31'b0, irq}, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule